// File: doc/BRIEF.md
# Two-Level Turn-Off Sequencer

This block is the digital controller on the output side of an isolated gate driver. It moves the driver stage between three levels: full off at the negative rail, an intermediate plateau, and full on. When a turn-on is requested, it first dumps the external timing capacitor for a fixed time. It then charges the capacitor from a main current source. A boost source takes over once a mid-level comparator trips. The gate turns on only when the final reference comparator fires. The block counts the cycles spent in this dump-and-charge phase in a saturating register. That count is replayed as the plateau hold time at the next turn-off, so turn-on and turn-off delays match.

A turn-off from the command input waits a short propagation delay. A turn-off from desaturation waits a longer sense delay. In both cases the stage drops to the plateau level, holds it for the stored count, and then goes to the negative rail. The plateau can never be cut short. A command that comes back during a plateau returns the output to full on once the plateau ends. The block allows only a limited number of such returns in a row before it forces the output off. Any error input (either undervoltage flag or a link failure) forces full off on the next cycle. After a forced off, the command must go low before a new turn-on is accepted. The analog current sources, the reference diode and the comparators lie outside the block and appear here as single-bit inputs and outputs.

Top module: `tlto_seq`

## Requirements
- R1: While and after reset, `drv_lvl` is 2'b00 and `cap_dump`, `src_main` and `src_boost` are all low.
- R2: A turn-on request raises `cap_dump` for exactly DUMP_CYC cycles. Then `src_main` rises while `drv_lvl` stays 2'b00. `drv_lvl` becomes 2'b10 in the cycle after `cmp_ref` is seen high.
- R3: During charging, the cycle after `cmp_mid` is seen high has `src_boost` high and `src_main` low. The two sources are never both high.
- R4: If `cmd_on` drops while the capacitor is being dumped or charged, the sequence aborts to full off and `drv_lvl` never reaches 2'b10.
- R5: The plateau hold time equals the number of cycles spent dumping and charging during the latest completed turn-on, saturated at 2**CNT_W-1.
- R6: After `cmd_on` falls while on, `drv_lvl` stays 2'b10 for PROP_CYC cycles. It is then 2'b01 for the stored hold time and then 2'b00.
- R7: A `desat_trip` while on keeps `drv_lvl` at 2'b10 for DESAT_CYC cycles before the plateau. After the plateau the output goes off even if `cmd_on` is high, and no new turn-on starts until `cmd_on` has been low.
- R8: A plateau always runs its full length. If `cmd_on` is high when it ends (and no desaturation caused it), `drv_lvl` returns to 2'b10.
- R9: After RING_MAX consecutive plateau-to-on returns, the next plateau ends in full off with `cmd_on` still high. Turn-on is then blocked until `cmd_on` has been low.
- R10: Any of `uv_prim`, `uv_sec` or `link_fail` drives `drv_lvl` to 2'b00 on the next cycle from any state, plateau included. After the error clears, turn-on stays blocked until `cmd_on` has been low.
- R11: `drv_lvl` encodes off as 2'b00, plateau as 2'b01 and on as 2'b10. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing step |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 1 | Filtered gate command (1 = on) |
| cmp_mid | input | 1 | Timing capacitor above the boost threshold |
| cmp_ref | input | 1 | Timing capacitor reached the reference level |
| desat_trip | input | 1 | Desaturation detected |
| uv_prim | input | 1 | Input-side undervoltage |
| uv_sec | input | 1 | Output-side undervoltage |
| link_fail | input | 1 | Isolation link transmission failure |
| drv_lvl | output | 2 | Drive level select: 00 off, 01 plateau, 10 on |
| cap_dump | output | 1 | Discharge the timing capacitor |
| src_main | output | 1 | Enable the main charge source |
| src_boost | output | 1 | Enable the boost charge source |

## Verification
The bench builds the sequencer with CNT_W=6, DUMP_CYC=10, PROP_CYC=4, DESAT_CYC=6 and RING_MAX=3. The narrow hold register lets one turn-on charge a few dozen cycles long hit the saturation value of 63, including the case that lands exactly on it. The short delays keep each plateau replay brief, so several measured lengths and both turn-off causes fit in one vector table. A ring limit of three lets the bench reach the forced turn-off after a handful of short off pulses.

// File: rtl/tlto_pkg.sv
package tlto_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_DUMP = 3'd1,
    ST_CHG  = 3'd2,
    ST_ON   = 3'd3,
    ST_ODLY = 3'd4,
    ST_PLAT = 3'd5
  } seq_st_e;

  localparam logic [1:0] LV_OFF  = 2'b00;
  localparam logic [1:0] LV_PLAT = 2'b01;
  localparam logic [1:0] LV_ON   = 2'b10;

  function automatic logic [1:0] lvl_of(input seq_st_e s);
    logic [1:0] v;
    case (s)
      ST_ON, ST_ODLY: v = LV_ON;
      ST_PLAT:        v = LV_PLAT;
      default:        v = LV_OFF;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tlto_down_tmr.sv
module tlto_down_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/tlto_hold_meas.sv
module tlto_hold_meas #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         cap,
  output logic [W-1:0] hold
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] meas;
  logic [W-1:0] meas_nx;

  assign meas_nx = (meas == SAT) ? SAT : meas + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      meas <= '0;
      hold <= SAT;
    end else begin
      if (clr) begin
        meas <= '0;
      end else if (run) begin
        meas <= meas_nx;
      end
      if (cap) begin
        hold <= meas_nx;
      end
    end
  end
endmodule

// File: rtl/tlto_ring_guard.sv
module tlto_ring_guard #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int RW = $clog2(LIMIT + 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !full) begin
      cnt <= cnt + RW'(1);
    end
  end

  assign full = (cnt == RW'(LIMIT));
endmodule

// File: rtl/tlto_seq.sv
module tlto_seq #(
  parameter int CNT_W     = 8,
  parameter int DUMP_CYC  = 10,
  parameter int PROP_CYC  = 4,
  parameter int DESAT_CYC = 6,
  parameter int RING_MAX  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_on,
  input  logic       cmp_mid,
  input  logic       cmp_ref,
  input  logic       desat_trip,
  input  logic       uv_prim,
  input  logic       uv_sec,
  input  logic       link_fail,
  output logic [1:0] drv_lvl,
  output logic       cap_dump,
  output logic       src_main,
  output logic       src_boost
);
  import tlto_pkg::*;

  localparam int DMAX = (DUMP_CYC > PROP_CYC)
                      ? ((DUMP_CYC > DESAT_CYC) ? DUMP_CYC : DESAT_CYC)
                      : ((PROP_CYC > DESAT_CYC) ? PROP_CYC : DESAT_CYC);
  localparam int DW = $clog2(DMAX + 1);
  localparam int TW = (CNT_W > DW) ? CNT_W : DW;

  seq_st_e        st, st_d;
  logic           cause, cause_d;
  logic           lock, lock_d;
  logic           boost_q, boost_d;
  logic           ld;
  logic [TW-1:0]  ld_val;
  logic           tmr_zero;
  logic           ring_inc, ring_full;
  logic           meas_clr, meas_run, meas_cap;
  logic [CNT_W-1:0] hold;
  logic           err;

  assign err = uv_prim | uv_sec | link_fail;

  tlto_down_tmr #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val), .zero(tmr_zero)
  );

  tlto_hold_meas #(.W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .clr(meas_clr), .run(meas_run),
    .cap(meas_cap), .hold(hold)
  );

  tlto_ring_guard #(.LIMIT(RING_MAX)) u_ring (
    .clk(clk), .rst(rst), .clr(st == ST_OFF), .inc(ring_inc), .full(ring_full)
  );

  assign meas_run = (st == ST_DUMP) || (st == ST_CHG);

  always_comb begin
    st_d     = st;
    cause_d  = cause;
    lock_d   = lock & cmd_on;
    ld       = 1'b0;
    ld_val   = '0;
    ring_inc = 1'b0;
    meas_clr = 1'b0;
    meas_cap = 1'b0;
    if (err) begin
      st_d   = ST_OFF;
      lock_d = 1'b1;
    end else begin
      case (st)
        ST_OFF: begin
          if (cmd_on && !lock) begin
            st_d     = ST_DUMP;
            ld       = 1'b1;
            ld_val   = TW'(DUMP_CYC - 1);
            meas_clr = 1'b1;
          end
        end
        ST_DUMP: begin
          if (!cmd_on)       st_d = ST_OFF;
          else if (tmr_zero) st_d = ST_CHG;
        end
        ST_CHG: begin
          if (!cmd_on) begin
            st_d = ST_OFF;
          end else if (cmp_ref) begin
            st_d     = ST_ON;
            meas_cap = 1'b1;
          end
        end
        ST_ON: begin
          if (desat_trip) begin
            st_d    = ST_ODLY;
            ld      = 1'b1;
            ld_val  = TW'(DESAT_CYC - 1);
            cause_d = 1'b1;
          end else if (!cmd_on) begin
            st_d    = ST_ODLY;
            ld      = 1'b1;
            ld_val  = TW'(PROP_CYC - 1);
            cause_d = 1'b0;
          end
        end
        ST_ODLY: begin
          if (tmr_zero) begin
            st_d   = ST_PLAT;
            ld     = 1'b1;
            ld_val = TW'(hold) - TW'(1);
          end
        end
        ST_PLAT: begin
          if (tmr_zero) begin
            if (cmd_on && !cause && !ring_full) begin
              st_d     = ST_ON;
              ring_inc = 1'b1;
            end else begin
              st_d   = ST_OFF;
              lock_d = cmd_on;
            end
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  assign boost_d = (st_d == ST_CHG) && (boost_q || ((st == ST_CHG) && cmp_mid));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OFF;
      cause     <= 1'b0;
      lock      <= 1'b0;
      boost_q   <= 1'b0;
      drv_lvl   <= LV_OFF;
      cap_dump  <= 1'b0;
      src_main  <= 1'b0;
      src_boost <= 1'b0;
    end else begin
      st        <= st_d;
      cause     <= cause_d;
      lock      <= lock_d;
      boost_q   <= boost_d;
      drv_lvl   <= lvl_of(st_d);
      cap_dump  <= (st_d == ST_DUMP);
      src_main  <= (st_d == ST_CHG) && !boost_d;
      src_boost <= boost_d;
    end
  end
endmodule

// File: rtl/tlto_seq_chk.sv
module tlto_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_on,
  input logic       cmp_ref,
  input logic       uv_prim,
  input logic       uv_sec,
  input logic       link_fail,
  input logic [1:0] drv_lvl,
  input logic       cap_dump,
  input logic       src_main,
  input logic       src_boost
);
  assert_lvl_code_R11: assert property (@(posedge clk) disable iff (rst)
    drv_lvl != 2'b11);

  assert_err_off_R10: assert property (@(posedge clk) disable iff (rst)
    (uv_prim || uv_sec || link_fail) |=> (drv_lvl == 2'b00));

  assert_src_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(src_main && src_boost));

  assert_dump_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cap_dump |-> (drv_lvl == 2'b00 && !src_main && !src_boost));

  assert_on_after_ref_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_lvl == 2'b10 && $past(drv_lvl) == 2'b00) |-> $past(cmp_ref));

  assert_plat_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (drv_lvl == 2'b01 && $past(drv_lvl) != 2'b01) |-> ($past(drv_lvl) == 2'b10));

  assert_plat_return_R8: assert property (@(posedge clk) disable iff (rst)
    (drv_lvl == 2'b10 && $past(drv_lvl) == 2'b01) |-> $past(cmd_on));
endmodule

bind tlto_seq tlto_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmp_ref(cmp_ref),
  .uv_prim(uv_prim), .uv_sec(uv_sec), .link_fail(link_fail),
  .drv_lvl(drv_lvl), .cap_dump(cap_dump), .src_main(src_main),
  .src_boost(src_boost)
);

// File: tb/sim_tlto_seq.sv
`timescale 1ns/1ps
module sim_tlto_seq;
  localparam int CNT_W     = 6;
  localparam int DUMP_CYC  = 10;
  localparam int PROP_CYC  = 4;
  localparam int DESAT_CYC = 6;
  localparam int RING_MAX  = 3;
  localparam int NVEC      = 6;
  // columns: extra charge cycles, cause (0 command, 1 desat), expected plateau length
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 11}, '{3, 1, 14}, '{20, 0, 31},
    '{45, 1, 56}, '{52, 0, 63}, '{60, 0, 63}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_on = 1'b0, cmp_mid = 1'b0, cmp_ref = 1'b0, desat_trip = 1'b0;
  logic uv_prim = 1'b0, uv_sec = 1'b0, link_fail = 1'b0;
  logic [1:0] drv_lvl;
  logic cap_dump, src_main, src_boost;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlto_seq #(
    .CNT_W(CNT_W), .DUMP_CYC(DUMP_CYC), .PROP_CYC(PROP_CYC),
    .DESAT_CYC(DESAT_CYC), .RING_MAX(RING_MAX)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmp_mid(cmp_mid),
    .cmp_ref(cmp_ref), .desat_trip(desat_trip), .uv_prim(uv_prim),
    .uv_sec(uv_sec), .link_fail(link_fail), .drv_lvl(drv_lvl),
    .cap_dump(cap_dump), .src_main(src_main), .src_boost(src_boost)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_lvl(input logic [1:0] v, output int n);
    n = 0;
    while (drv_lvl == v && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_dump(output int n);
    n = 0;
    while (cap_dump && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_on(input int w);
    int n;
    cmd_on = 1'b1;
    @(negedge clk);
    run_dump(n);
    chk("R2 discharge length", n, DUMP_CYC);
    chk("R2 main source in charge", int'(src_main), 1);
    chk("R2 level off while charging", int'(drv_lvl), 0);
    repeat (w) @(negedge clk);
    cmp_ref = 1'b1;
    @(negedge clk);
    cmp_ref = 1'b0;
    chk("R2 on after threshold", int'(drv_lvl), 2);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 and R11: reset levels
    chk("R1 level in reset", int'(drv_lvl), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 level after reset", int'(drv_lvl), 0);
    chk("R1 dump after reset", int'(cap_dump), 0);
    chk("R1 sources after reset", int'(src_main) + int'(src_boost), 0);

    // table walk: R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      do_on(VEC[i][0]);
      repeat (2) @(negedge clk);
      if (VEC[i][1] == 1) begin
        desat_trip = 1'b1;
        @(negedge clk);
        desat_trip = 1'b0;
      end else begin
        cmd_on = 1'b0;
        @(negedge clk);
      end
      run_lvl(2'b10, n);
      chk((VEC[i][1] == 1) ? "R7 desat delay" : "R6 command delay", n,
          (VEC[i][1] == 1) ? DESAT_CYC : PROP_CYC);
      run_lvl(2'b01, n);
      chk("R5 plateau equals measured time", n, VEC[i][2]);
      chk("R6 off after plateau", int'(drv_lvl), 0);
      if (VEC[i][1] == 1) begin
        repeat (3) @(negedge clk);
        chk("R7 no restart while command held", int'(cap_dump), 0);
        chk("R7 stays off", int'(drv_lvl), 0);
        cmd_on = 1'b0;
      end
      repeat (3) @(negedge clk);
    end

    // R3 boost takeover, then R8 and R9 with a 12-cycle plateau
    cmd_on = 1'b1;
    @(negedge clk);
    run_dump(n);
    chk("R3 main first", int'(src_main), 1);
    chk("R3 boost idle first", int'(src_boost), 0);
    cmp_mid = 1'b1;
    @(negedge clk);
    chk("R3 boost active", int'(src_boost), 1);
    chk("R3 main released", int'(src_main), 0);
    cmp_ref = 1'b1;
    @(negedge clk);
    cmp_ref = 1'b0;
    cmp_mid = 1'b0;
    chk("R3 boost off once on", int'(src_boost), 0);
    for (int k = 0; k <= RING_MAX; k++) begin
      cmd_on = 1'b0;
      @(negedge clk);
      cmd_on = 1'b1;
      run_lvl(2'b10, n);
      chk("R8 delay before plateau", n, PROP_CYC);
      chk("R11 plateau code", int'(drv_lvl), 1);
      run_lvl(2'b01, n);
      chk("R8 plateau not shortened", n, DUMP_CYC + 2);
      if (k < RING_MAX) chk("R8 return to on", int'(drv_lvl), 2);
      else              chk("R9 forced off", int'(drv_lvl), 0);
    end
    repeat (4) @(negedge clk);
    chk("R9 locked after forced off", int'(cap_dump) + int'(drv_lvl), 0);
    cmd_on = 1'b0;
    @(negedge clk);
    cmd_on = 1'b1;
    @(negedge clk);
    chk("R9 rearmed after command low", int'(cap_dump), 1);

    // R4 aborts in dump and in charge
    cmd_on = 1'b0;
    @(negedge clk);
    chk("R4 dump abort", int'(cap_dump), 0);
    chk("R4 dump abort level", int'(drv_lvl), 0);
    cmd_on = 1'b1;
    @(negedge clk);
    run_dump(n);
    repeat (3) @(negedge clk);
    chk("R4 still off in charge", int'(drv_lvl), 0);
    cmd_on = 1'b0;
    @(negedge clk);
    chk("R4 charge abort source", int'(src_main), 0);
    chk("R4 charge abort level", int'(drv_lvl), 0);
    repeat (2) @(negedge clk);

    // R10 errors
    do_on(0);
    @(negedge clk);
    uv_sec = 1'b1;
    @(negedge clk);
    chk("R10 undervoltage forces off", int'(drv_lvl), 0);
    repeat (3) @(negedge clk);
    chk("R10 off during error", int'(cap_dump) + int'(drv_lvl), 0);
    uv_sec = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 locked after error", int'(cap_dump) + int'(drv_lvl), 0);
    cmd_on = 1'b0;
    @(negedge clk);
    do_on(0);
    cmd_on = 1'b0;
    @(negedge clk);
    run_lvl(2'b10, n);
    repeat (3) @(negedge clk);
    chk("R10 in plateau before fault", int'(drv_lvl), 1);
    link_fail = 1'b1;
    @(negedge clk);
    chk("R10 link fault cuts plateau", int'(drv_lvl), 0);
    link_fail = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule